// File: doc/BRIEF.md
# Probabilistic-Recirculation Heavy-Hitter Tracker

The tracker keeps an estimate of the largest flows in a packet stream using a short pipeline of hashed stages. Each stage owns a table of flow-ID/count entries and touches exactly one entry per packet, chosen by a stage-specific multiplicative hash of the flow ID. A new packet whose flow ID is found in one of its visited entries bumps that count. Otherwise the tracker takes the smallest count among the visited entries as an approximate minimum, flips a power-of-two biased coin derived from that minimum, and reports whether the flow should be admitted. Admission is done by a second, recirculated pass of the packet. That pass carries the flow ID, the stage that held the minimum, and the minimum count, and it rewrites only that one entry.

Packets enter on a valid/ready stream and leave as one result per new packet on a valid/ready stream. A result is either a hit report or a miss report with the minimum, its stage and the coin outcome. Recirculated packets produce no result. Back-pressure rules: an input transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or being drained. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes, including the table writes. The result holds steady until it is taken. A plain combinational query port reads any table entry.

Top module: `hh_tracker`

## Requirements
- R1: After reset every entry of every stage reads valid=0, ID=0 and count=100, and `out_valid` is low.
- R2: Stage s visits index bits [31:26] of (flow × K_s) mod 2^32, with K_0=0x9E3779B1, K_1=0x85EBCA77 and K_2=0xC2B2AE3D.
- R3: For a new packet, the lowest-numbered stage whose visited entry is valid and holds the same ID gets its count raised by one, saturating at 65535. The result has `out_hit`=1, `out_recirc`=0, `out_stage` set to that stage and `out_count` set to the new count.
- R4: When no stage matches, `out_hit`=0, `out_count` is the smallest visited count and `out_stage` is its stage, with the lower stage winning a tie. No entry changes.
- R5: On a miss, N = min(ceil(log2(`out_count`+1)), 31). `out_recirc`=1 exactly when the low N bits of a 32-bit state are all zero. The state starts at 0xACE12B57. After each miss it is shifted right one place and XORed with 0x80200003 if the bit shifted out was 1.
- R6: Every accepted new packet (`in_recirc`=0) yields exactly one result, in acceptance order, with `out_flow` equal to its ID. Accepted recirculated packets yield none.
- R7: A recirculated packet with stage field S and count C sets the entry at stage S and its R2 index to valid=1, ID=flow and count=min(C+1, 65535). It changes no other entry.
- R8: A packet accepted after another sees all of that packet's table updates, including a recirculated write accepted in the cycle just before it.
- R9: `in_ready` is high whenever `out_valid` is low. While `out_valid` is high and `out_ready` is low, the result fields stay stable on the next cycle and nothing is lost or duplicated.
- R10: `q_valid`, `q_flow` and `q_count` show the entry at stage `q_stage` and index `q_index` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Tracker can take a packet |
| in_flow | input | 32 | Flow ID |
| in_recirc | input | 1 | Packet is a recirculated admission pass |
| in_stage | input | 2 | Target stage of a recirculated pass |
| in_count | input | 16 | Minimum count carried by a recirculated pass |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_flow | output | 32 | Flow ID of the result |
| out_hit | output | 1 | Flow was found and counted |
| out_recirc | output | 1 | Admission coin succeeded; recirculate a copy |
| out_stage | output | 2 | Matched stage or minimum stage |
| out_count | output | 16 | New count on a hit, minimum count on a miss |
| q_stage | input | 2 | Query stage |
| q_index | input | 6 | Query index |
| q_valid | output | 1 | Queried entry valid bit |
| q_flow | output | 32 | Queried entry ID |
| q_count | output | 16 | Queried entry count |

## Verification
The main function is driven with a small pool of repeating flows, which tells hits apart from misses once flows are admitted. Synthetic recirculated writes with tiny counts drive the minimum near zero, so the coin runs with N from 1 up through 7 and the bench's model of the random state is checked against every outcome. Back-to-back recirculate-then-lookup pairs separate correct forwarding from stale reads. Writes near 65535 expose a wrapping counter. Random `out_ready` gaps over thousands of packets separate a correct stall from a lost, duplicated or changed result.

// File: rtl/hh_pkg.sv
`timescale 1ns/1ps
package hh_pkg;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  // Odd multiplier per stage; stages beyond the third reuse with a twist.
  function automatic logic [31:0] hash_key(input int s);
    logic [31:0] k;
    case (s % 3)
      0:       k = 32'h9E37_79B1;
      1:       k = 32'h85EB_CA77;
      default: k = 32'hC2B2_AE3D;
    endcase
    return k ^ (32'(s / 3) << 1);
  endfunction

  // Number of fair binary coins needed: smallest n with 2^n >= m+1, capped.
  function automatic int unsigned coin_bits(input logic [31:0] m, input int unsigned cap);
    logic [32:0]  v;
    int unsigned  n;
    v = {1'b0, m} + 33'd1;
    n = cap;
    for (int i = 31; i >= 0; i--) begin
      if ((33'd1 << i) >= v) n = i;
    end
    if (n > cap) n = cap;
    return n;
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/hh_hash.sv
`timescale 1ns/1ps
module hh_hash #(
  parameter int STAGE_NUM = 0,
  parameter int ID_W      = 32,
  parameter int IDX_W     = 6
) (
  input  logic [ID_W-1:0]  flow,
  output logic [IDX_W-1:0] idx
);
  localparam logic [ID_W-1:0] KEY = ID_W'(hh_pkg::hash_key(STAGE_NUM));

  logic [ID_W-1:0] prod;

  always_comb begin
    prod = flow * KEY;
    idx  = IDX_W'(prod >> (ID_W - IDX_W));
  end
endmodule

// File: rtl/hh_stage.sv
`timescale 1ns/1ps
module hh_stage #(
  parameter int STAGE_NUM = 0,
  parameter int ID_W      = 32,
  parameter int IDX_W     = 6,
  parameter int CNT_W     = 16,
  parameter int STG_W     = 2,
  parameter int INIT_CNT  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  // packet entering this stage
  input  logic             i_valid,
  input  logic             i_recirc,
  input  logic [ID_W-1:0]  i_flow,
  input  logic [STG_W-1:0] i_rstage,
  input  logic [CNT_W-1:0] i_rcount,
  input  logic             i_hit,
  input  logic [CNT_W-1:0] i_best_cnt,
  input  logic [STG_W-1:0] i_best_stage,
  // packet leaving this stage (registered)
  output logic             o_valid,
  output logic             o_recirc,
  output logic [ID_W-1:0]  o_flow,
  output logic [STG_W-1:0] o_rstage,
  output logic [CNT_W-1:0] o_rcount,
  output logic             o_hit,
  output logic [CNT_W-1:0] o_best_cnt,
  output logic [STG_W-1:0] o_best_stage,
  // read-only query
  input  logic [IDX_W-1:0] q_index,
  output logic             q_valid,
  output logic [ID_W-1:0]  q_flow,
  output logic [CNT_W-1:0] q_count
);
  localparam int              DEPTH   = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_INI = CNT_W'(INIT_CNT);
  localparam logic [STG_W-1:0] MY_STG  = STG_W'(STAGE_NUM);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic             tbl_v   [DEPTH];
  logic [ID_W-1:0]  tbl_id  [DEPTH];
  logic [CNT_W-1:0] tbl_cnt [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] inc_cnt;
  logic             look_hit;
  logic             take_min;
  logic             rc_write;

  hh_hash #(
    .STAGE_NUM(STAGE_NUM),
    .ID_W     (ID_W),
    .IDX_W    (IDX_W)
  ) u_hash (
    .flow(i_flow),
    .idx (idx)
  );

  always_comb begin
    cur_cnt  = tbl_cnt[idx];
    inc_cnt  = sat_inc(cur_cnt);
    look_hit = i_valid && !i_recirc && !i_hit && tbl_v[idx] && (tbl_id[idx] == i_flow);
    take_min = i_valid && !i_recirc && !i_hit && !look_hit &&
               ((STAGE_NUM == 0) || (cur_cnt < i_best_cnt));
    rc_write = i_valid && i_recirc && (i_rstage == MY_STG);
  end

  // table storage: updated only while the pipeline advances
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        tbl_v[k]   <= 1'b0;
        tbl_id[k]  <= '0;
        tbl_cnt[k] <= CNT_INI;
      end
    end else if (adv) begin
      if (look_hit) begin
        tbl_cnt[idx] <= inc_cnt;
      end else if (rc_write) begin
        tbl_v[idx]   <= 1'b1;
        tbl_id[idx]  <= i_flow;
        tbl_cnt[idx] <= sat_inc(i_rcount);
      end
    end
  end

  // pipeline register toward the next stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid      <= 1'b0;
      o_recirc     <= 1'b0;
      o_flow       <= '0;
      o_rstage     <= '0;
      o_rcount     <= '0;
      o_hit        <= 1'b0;
      o_best_cnt   <= '0;
      o_best_stage <= '0;
    end else if (adv) begin
      o_valid      <= i_valid;
      o_recirc     <= i_recirc;
      o_flow       <= i_flow;
      o_rstage     <= i_rstage;
      o_rcount     <= i_rcount;
      o_hit        <= i_hit || look_hit;
      if (look_hit) begin
        o_best_cnt   <= inc_cnt;
        o_best_stage <= MY_STG;
      end else if (take_min) begin
        o_best_cnt   <= cur_cnt;
        o_best_stage <= MY_STG;
      end else begin
        o_best_cnt   <= i_best_cnt;
        o_best_stage <= i_best_stage;
      end
    end
  end

  always_comb begin
    q_valid = tbl_v[q_index];
    q_flow  = tbl_id[q_index];
    q_count = tbl_cnt[q_index];
  end
endmodule

// File: rtl/hh_coin.sv
`timescale 1ns/1ps
module hh_coin #(
  parameter int          CNT_W   = 16,
  parameter int          MAX_N   = 31,
  parameter logic [31:0] SEED    = 32'hACE1_2B57
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] min_cnt,
  output logic             coin
);
  logic [31:0] state;
  logic [31:0] mask;
  int unsigned nbits;

  always_comb begin
    nbits = hh_pkg::coin_bits(32'(min_cnt), MAX_N);
    mask  = (nbits == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - nbits));
    coin  = ((state & mask) == 32'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= hh_pkg::lfsr_next(state);
  end
endmodule

// File: rtl/hh_tracker.sv
`timescale 1ns/1ps
module hh_tracker #(
  parameter int          STAGES   = 3,
  parameter int          ID_W     = 32,
  parameter int          IDX_W    = 6,
  parameter int          CNT_W    = 16,
  parameter int          INIT_CNT = 100,
  parameter int          MAX_N    = 31,
  parameter logic [31:0] SEED     = 32'hACE1_2B57,
  localparam int         STG_W    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_flow,
  input  logic             in_recirc,
  input  logic [STG_W-1:0] in_stage,
  input  logic [CNT_W-1:0] in_count,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_flow,
  output logic             out_hit,
  output logic             out_recirc,
  output logic [STG_W-1:0] out_stage,
  output logic [CNT_W-1:0] out_count,
  input  logic [STG_W-1:0] q_stage,
  input  logic [IDX_W-1:0] q_index,
  output logic             q_valid,
  output logic [ID_W-1:0]  q_flow,
  output logic [CNT_W-1:0] q_count
);
  // pipeline taps: index 0 is the accepted input, index STAGES the last stage output
  logic             p_valid      [STAGES+1];
  logic             p_recirc     [STAGES+1];
  logic [ID_W-1:0]  p_flow       [STAGES+1];
  logic [STG_W-1:0] p_rstage     [STAGES+1];
  logic [CNT_W-1:0] p_rcount     [STAGES+1];
  logic             p_hit        [STAGES+1];
  logic [CNT_W-1:0] p_best_cnt   [STAGES+1];
  logic [STG_W-1:0] p_best_stage [STAGES+1];

  logic             sq_valid [STAGES];
  logic [ID_W-1:0]  sq_flow  [STAGES];
  logic [CNT_W-1:0] sq_count [STAGES];

  logic adv;
  logic coin;
  logic decide;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_comb begin
    p_valid[0]      = in_valid && adv;
    p_recirc[0]     = in_recirc;
    p_flow[0]       = in_flow;
    p_rstage[0]     = in_stage;
    p_rcount[0]     = in_count;
    p_hit[0]        = 1'b0;
    p_best_cnt[0]   = '0;
    p_best_stage[0] = '0;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    hh_stage #(
      .STAGE_NUM(s),
      .ID_W     (ID_W),
      .IDX_W    (IDX_W),
      .CNT_W    (CNT_W),
      .STG_W    (STG_W),
      .INIT_CNT (INIT_CNT)
    ) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv         (adv),
      .i_valid     (p_valid[s]),
      .i_recirc    (p_recirc[s]),
      .i_flow      (p_flow[s]),
      .i_rstage    (p_rstage[s]),
      .i_rcount    (p_rcount[s]),
      .i_hit       (p_hit[s]),
      .i_best_cnt  (p_best_cnt[s]),
      .i_best_stage(p_best_stage[s]),
      .o_valid     (p_valid[s+1]),
      .o_recirc    (p_recirc[s+1]),
      .o_flow      (p_flow[s+1]),
      .o_rstage    (p_rstage[s+1]),
      .o_rcount    (p_rcount[s+1]),
      .o_hit       (p_hit[s+1]),
      .o_best_cnt  (p_best_cnt[s+1]),
      .o_best_stage(p_best_stage[s+1]),
      .q_index     (q_index),
      .q_valid     (sq_valid[s]),
      .q_flow      (sq_flow[s]),
      .q_count     (sq_count[s])
    );
  end

  // coin is drawn only for a new packet that missed every stage
  assign decide = adv && p_valid[STAGES] && !p_recirc[STAGES] && !p_hit[STAGES];

  hh_coin #(
    .CNT_W(CNT_W),
    .MAX_N(MAX_N),
    .SEED (SEED)
  ) u_coin (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (decide),
    .min_cnt(p_best_cnt[STAGES]),
    .coin   (coin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_flow   <= '0;
      out_hit    <= 1'b0;
      out_recirc <= 1'b0;
      out_stage  <= '0;
      out_count  <= '0;
    end else if (adv) begin
      out_valid  <= p_valid[STAGES] && !p_recirc[STAGES];
      out_flow   <= p_flow[STAGES];
      out_hit    <= p_hit[STAGES];
      out_recirc <= !p_hit[STAGES] && coin;
      out_stage  <= p_best_stage[STAGES];
      out_count  <= p_best_cnt[STAGES];
    end
  end

  always_comb begin
    q_valid = 1'b0;
    q_flow  = '0;
    q_count = '0;
    for (int s = 0; s < STAGES; s++) begin
      if (q_stage == STG_W'(s)) begin
        q_valid = sq_valid[s];
        q_flow  = sq_flow[s];
        q_count = sq_count[s];
      end
    end
  end
endmodule

// File: rtl/hh_tracker_chk.sv
`timescale 1ns/1ps
module hh_tracker_chk #(
  parameter int STAGES = 3,
  parameter int ID_W   = 32,
  parameter int CNT_W  = 16,
  parameter int STG_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ID_W-1:0]  out_flow,
  input logic             out_hit,
  input logic             out_recirc,
  input logic [STG_W-1:0] out_stage,
  input logic [CNT_W-1:0] out_count
);
  // R1: reset empties the result register
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R3: a hit never asks for recirculation
  p_hit_no_recirc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> !out_recirc);

  // R3: the saturating increment never wraps to zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> out_count != '0);

  // R4: the reported stage is a real stage
  p_stage_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_stage) < STAGES);

  // R5: a zero minimum needs no coin and always admits
  p_zero_min_admit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit && out_count == '0 |-> out_recirc);

  // R9: a stalled result stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flow) && $stable(out_hit) &&
      $stable(out_recirc) && $stable(out_stage) && $stable(out_count));

  // R9: an empty output register always accepts
  p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind hh_tracker hh_tracker_chk #(
  .STAGES(STAGES),
  .ID_W  (ID_W),
  .CNT_W (CNT_W),
  .STG_W (STG_W)
) u_chk (.*);

// File: tb/test_hh_tracker.sv
`timescale 1ns/1ps
module test_hh_tracker;
  localparam int NS = 3;
  localparam int NI = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_flow = '0;
  logic        in_recirc = 1'b0;
  logic [1:0]  in_stage = '0;
  logic [15:0] in_count = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_flow;
  logic        out_hit;
  logic        out_recirc;
  logic [1:0]  out_stage;
  logic [15:0] out_count;
  logic [1:0]  q_stage = '0;
  logic [5:0]  q_index = '0;
  logic        q_valid;
  logic [31:0] q_flow;
  logic [15:0] q_count;

  always #4 clk = ~clk;

  hh_tracker i_hh_tracker (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    logic [31:0] f;
    logic        hit;
    logic        rc;
    logic [1:0]  st;
    logic [15:0] cnt;
  } exp_t;

  typedef struct packed {
    logic [31:0] f;
    logic [1:0]  st;
    logic [15:0] cnt;
  } rq_t;

  exp_t eq[$];
  rq_t  rq[$];

  // bench model
  logic        m_v   [NS][NI];
  logic [31:0] m_id  [NS][NI];
  logic [15:0] m_cnt [NS][NI];
  logic [31:0] m_lfsr;

  function automatic logic [5:0] hidx(input int s, input logic [31:0] f);
    logic [31:0] k, p;
    k = (s == 0) ? 32'h9E3779B1 : (s == 1) ? 32'h85EBCA77 : 32'hC2B2AE3D;
    p = f * k;
    return p[31:26];
  endfunction

  function automatic logic [15:0] sat1(input logic [15:0] c);
    return (c == 16'hFFFF) ? c : c + 16'd1;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NI; i++) begin
        m_v[s][i] = 0; m_id[s][i] = 0; m_cnt[s][i] = 16'd100;
      end
    m_lfsr = 32'hACE12B57;
  endtask

  task automatic model_new(input logic [31:0] f);
    exp_t e;
    int   n;
    logic [31:0] mask;
    e = '0; e.f = f;
    for (int s = 0; s < NS; s++) begin
      if (!e.hit && m_v[s][hidx(s, f)] && m_id[s][hidx(s, f)] == f) begin
        m_cnt[s][hidx(s, f)] = sat1(m_cnt[s][hidx(s, f)]);
        e.hit = 1; e.st = 2'(s); e.cnt = m_cnt[s][hidx(s, f)];
      end
    end
    if (!e.hit) begin
      e.st = 0; e.cnt = m_cnt[0][hidx(0, f)];
      for (int s = 1; s < NS; s++)
        if (m_cnt[s][hidx(s, f)] < e.cnt) begin e.cnt = m_cnt[s][hidx(s, f)]; e.st = 2'(s); end
      n = 0;
      while (n < 31 && (33'd1 << n) < ({17'd0, e.cnt} + 33'd1)) n++;
      mask = (n == 0) ? 32'd0 : (32'hFFFFFFFF >> (32 - n));
      e.rc = ((m_lfsr & mask) == 0);
      m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 32'h80200003) : (m_lfsr >> 1);
      if (e.rc) rq.push_back('{f: f, st: e.st, cnt: e.cnt});
    end
    eq.push_back(e);
  endtask

  task automatic model_rc(input logic [31:0] f, input logic [1:0] st, input logic [15:0] c);
    m_v[st][hidx(st, f)]   = 1;
    m_id[st][hidx(st, f)]  = f;
    m_cnt[st][hidx(st, f)] = sat1(c);
  endtask

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // drive one packet; returns just after it has been taken
  task automatic send(input logic rc, input logic [31:0] f, input logic [1:0] st,
                      input logic [15:0] c, input bit stall_en);
    @(negedge clk);
    out_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
    in_valid = 1; in_recirc = rc; in_flow = f; in_stage = st; in_count = c;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
      #1;
    end
    if (rc) model_rc(f, st, c); else model_new(f);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk); out_ready = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic query(input int s, input int i, output logic v, output logic [31:0] f, output logic [15:0] c);
    q_stage = 2'(s); q_index = 6'(i);
    #1; v = q_valid; f = q_flow; c = q_count;
  endtask

  // result monitor: R3 R4 R5 R6 R9
  exp_t prev_o;
  bit   prev_stall = 0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && {out_flow, out_hit, out_recirc, out_stage, out_count} == prev_o,
                "R9 held result", 48'({out_valid, out_count}), 48'({1'b1, prev_o.cnt}));
        prev_stall = out_valid && !out_ready;
        prev_o = {out_flow, out_hit, out_recirc, out_stage, out_count};
        if (out_valid && out_ready) begin
          if (eq.size() == 0) check(0, "R6 unexpected result", 48'(out_flow), 48'(0));
          else begin
            exp_t e;
            e = eq.pop_front();
            check(out_flow == e.f, "R6 flow order", 48'(out_flow), 48'(e.f));
            check(out_hit == e.hit, "R3 hit flag", 48'(out_hit), 48'(e.hit));
            check({out_stage, out_count} == {e.st, e.cnt}, e.hit ? "R3 hit stage/count" : "R4 min stage/count",
                  48'({out_stage, out_count}), 48'({e.st, e.cnt}));
            check(out_recirc == e.rc, "R5 coin", 48'(out_recirc), 48'(e.rc));
          end
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [31:0] f;
    logic [15:0] c;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset contents
    check(!out_valid, "R1 out_valid after reset", 48'(out_valid), 48'(0));
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NI; i++) begin
        query(s, i, v, f, c);
        check(!v && f == 0 && c == 16'd100, "R1 reset entry", 48'({v, f[14:0], c}), 48'({1'b0, 15'd0, 16'd100}));
      end

    // R4/R5: fresh flows all miss against the initial counts
    for (int k = 0; k < 8; k++) send(0, 32'h1000 + 32'(k) * 32'h3F1, 0, 0, 0);
    drain();

    // R7 + R2: recirculated write lands at the hashed index of its stage
    send(1, 32'hCAFE0001, 2'd1, 16'd7, 0);
    drain();
    query(1, hidx(1, 32'hCAFE0001), v, f, c);
    check(v && f == 32'hCAFE0001 && c == 16'd8, "R7 R2 recirc write", 48'({v, f[14:0], c}), 48'({1'b1, 15'h0001, 16'd8}));
    query(0, hidx(0, 32'hCAFE0001), v, f, c);
    check(f != 32'hCAFE0001, "R7 other stage untouched", 48'(f), 48'(0));

    // R3: the admitted flow now hits
    send(0, 32'hCAFE0001, 0, 0, 0);
    drain();

    // R8: write then lookup on back-to-back cycles
    send(1, 32'hDEAD0001, 2'd1, 16'd3, 0);
    send(0, 32'hDEAD0001, 0, 0, 0);
    drain();
    query(1, hidx(1, 32'hDEAD0001), v, f, c);
    check(c == 16'd5, "R8 lookup saw previous write", 48'(c), 48'(5));

    // R3/R7 saturation
    send(1, 32'hBEEF0002, 2'd2, 16'hFFFE, 0);
    drain();
    query(2, hidx(2, 32'hBEEF0002), v, f, c);
    check(c == 16'hFFFF, "R7 count+1 reaches max", 48'(c), 48'hFFFF);
    send(0, 32'hBEEF0002, 0, 0, 0);
    drain();
    query(2, hidx(2, 32'hBEEF0002), v, f, c);
    check(c == 16'hFFFF, "R3 increment saturates", 48'(c), 48'hFFFF);
    send(1, 32'hBEEF0003, 2'd0, 16'hFFFF, 0);
    drain();
    query(0, hidx(0, 32'hBEEF0003), v, f, c);
    check(c == 16'hFFFF, "R7 write saturates", 48'(c), 48'hFFFF);

    // sweep with random back-pressure and feedback recirculation
    for (int op = 0; op < 4000; op++) begin
      int r;
      r = int'($urandom % 16);
      if (rq.size() != 0 && r < 6) begin
        rq_t q;
        q = rq.pop_front();
        send(1, q.f, q.st, q.cnt, 1);
      end else if (r < 8) begin
        send(1, 32'h500 + 32'($urandom % 48), 2'($urandom % 3), 16'($urandom % 6), 1);
      end else begin
        send(0, 32'h500 + 32'($urandom % 48), 0, 0, 1);
      end
    end
    drain();
    check(eq.size() == 0, "R6 all results delivered", 48'(eq.size()), 48'(0));

    // R10: full table readback
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NI; i++) begin
        query(s, i, v, f, c);
        check(v == m_v[s][i] && f == m_id[s][i] && c == m_cnt[s][i], "R10 query readback",
              48'({v, f[14:0], c}), 48'({m_v[s][i], m_id[s][i][14:0], m_cnt[s][i]}));
      end

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule